// File: doc/BRIEF.md
# Data Watchpoint Comparator Unit

This block watches a processor's data-access bus and signals when an access lands inside a programmed address window. Each of its comparators holds a compare value, a mask size and a function code. The mask size sets how many low address bits the comparator ignores, so one comparator covers an aligned power-of-two region. The function code picks whether reads, writes or any access may match.

The block also holds a free-running 32-bit cycle counter and a control register. Comparator 0 can be switched from address matching to cycle-count matching, so it fires when the counter equals its compare value.

Software reaches every register through a simple 32-bit read/write port with byte offsets. Each comparator drives a one-cycle match pulse. It also keeps a sticky matched flag, which software reads and clears through the comparator's function register.

Top module: `dwatch_unit`

## Requirements
- R1: After reset every register reads zero except the control register's comparator-count field, and all match pulses are low.
- R2: The control register (offset 0x000) returns the number of comparators (4) in bits [31:28], which ignore writes. It returns the counter enable in bit 0, and all other bits read zero.
- R3: While control bit 0 is 1, the cycle counter (offset 0x004) adds one each clock. While it is 0, the counter holds its value.
- R4: A write to offset 0x004 loads the counter with the written data, taking priority over counting. The counter wraps from 0xFFFFFFFF to 0.
- R5: Comparator n occupies offsets 0x020+0x10*n. The 32-bit compare value is at +0, the mask size at +4 (bits [3:0] kept, the rest read zero) and the function code at +8 (bits [3:0] kept).
- R6: An address match requires (bus_addr & ~(2^mask-1)) == (value & ~(2^mask-1)) with bus_valid high. Mask 0 is an exact byte match and mask 15 covers an aligned 32 KB region.
- R7: Function code 5 matches reads only (bus_write=0), 6 matches writes only (bus_write=1) and 7 matches both. Code 0 and every code other than 1, 5, 6 and 7 never match.
- R8: Function code 1 on comparator 0 fires when the cycle counter equals the compare value. On any other comparator, code 1 behaves as disabled.
- R9: match_pulse[n] goes high for exactly one cycle, in the cycle after the qualifying access (or counter value).
- R10: Bit 24 of comparator n's function register is a sticky flag, set by any match of that comparator. Reading that register returns the flag and then clears it.
- R11: Offsets that hold no register read as zero, and writes to them change nothing.
- R12: reg_rdata carries the read value in the cycle after reg_rd_en. It is zero in a cycle that follows no read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| bus_valid | input | 1 | Watched bus access valid |
| bus_write | input | 1 | Watched access is a write (1) or read (0) |
| bus_addr | input | 32 | Watched access byte address |
| match_pulse | output | 4 | Per-comparator one-cycle match event |

## Verification
A corrupted mask or compare value shows in the match pulse for the very next access that falls on the wrong side of the window edge. Random addresses are clustered near the programmed values so that such edges are crossed often. A bad counter step or load appears at the first read of offset 0x004 after it, since back-to-back reads see consecutive values. A flag that fails to set or clear shows on the next pair of reads of the function register, and the bench checks each access's pulse vector one cycle later.

// File: rtl/dwatch_pkg.sv
package dwatch_pkg;
    localparam int NUM_COMP_DEF = 4;
    localparam int DATA_W       = 32;
    localparam int MASK_W       = 4;
    localparam int FUNC_W       = 4;
    localparam int REG_ADDR_W   = 12;
    localparam int FLAG_BIT     = 24;
    localparam int ID_LSB       = 28;

    localparam logic [REG_ADDR_W-1:0] OFF_CTRL = 12'h000;
    localparam logic [REG_ADDR_W-1:0] OFF_CNT  = 12'h004;
    localparam int COMP_BASE   = 32'h20;
    localparam int COMP_STRIDE = 32'h10;
    localparam int SUB_VAL     = 0;
    localparam int SUB_MASK    = 4;
    localparam int SUB_FUNC    = 8;

    localparam logic [FUNC_W-1:0] FN_OFF   = 4'd0;
    localparam logic [FUNC_W-1:0] FN_CYCLE = 4'd1;
    localparam logic [FUNC_W-1:0] FN_READ  = 4'd5;
    localparam logic [FUNC_W-1:0] FN_WRITE = 4'd6;
    localparam logic [FUNC_W-1:0] FN_ANY   = 4'd7;

    typedef enum logic [2:0] {
        SEL_NONE, SEL_CTRL, SEL_CNT, SEL_CVAL, SEL_CMASK, SEL_CFUNC
    } reg_sel_e;

    typedef struct packed {
        logic [DATA_W-1:0] value;
        logic [MASK_W-1:0] mask;
        logic [FUNC_W-1:0] func;
    } comp_cfg_t;

    function automatic logic [REG_ADDR_W-1:0] comp_off(int n, int sub);
        return REG_ADDR_W'(COMP_BASE + COMP_STRIDE * n + sub);
    endfunction

    function automatic logic [DATA_W-1:0] keep_mask(logic [MASK_W-1:0] m);
        return ~((DATA_W'(1) << m) - DATA_W'(1));
    endfunction

    function automatic logic in_window(logic [DATA_W-1:0] a,
                                       logic [DATA_W-1:0] v,
                                       logic [MASK_W-1:0] m);
        return (a & keep_mask(m)) == (v & keep_mask(m));
    endfunction
endpackage

// File: rtl/dwatch_decode.sv
module dwatch_decode
    import dwatch_pkg::*;
#(
    parameter int NUM_COMP = NUM_COMP_DEF,
    localparam int IDX_W = (NUM_COMP > 1) ? $clog2(NUM_COMP) : 1
) (
    input  logic [REG_ADDR_W-1:0] addr,
    output reg_sel_e              sel,
    output logic [IDX_W-1:0]      idx
);
    always_comb begin
        sel = SEL_NONE;
        idx = '0;
        if (addr == OFF_CTRL) sel = SEL_CTRL;
        if (addr == OFF_CNT)  sel = SEL_CNT;
        for (int n = 0; n < NUM_COMP; n++) begin
            if (addr == comp_off(n, SUB_VAL)) begin
                sel = SEL_CVAL;
                idx = IDX_W'(n);
            end
            if (addr == comp_off(n, SUB_MASK)) begin
                sel = SEL_CMASK;
                idx = IDX_W'(n);
            end
            if (addr == comp_off(n, SUB_FUNC)) begin
                sel = SEL_CFUNC;
                idx = IDX_W'(n);
            end
        end
    end
endmodule

// File: rtl/dwatch_cyccnt.sv
module dwatch_cyccnt
    import dwatch_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic              load,
    input  logic [DATA_W-1:0] load_val,
    output logic [DATA_W-1:0] count
);
    always_ff @(posedge clk) begin
        if (rst)       count <= '0;
        else if (load) count <= load_val;
        else if (run)  count <= count + DATA_W'(1);
    end
endmodule

// File: rtl/dwatch_comparator.sv
module dwatch_comparator
    import dwatch_pkg::*;
#(
    parameter bit CYCLE_OK = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_value,
    input  logic              wr_mask,
    input  logic              wr_func,
    input  logic [DATA_W-1:0] wdata,
    input  logic              flag_clr,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [DATA_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] cyc_cnt,
    output comp_cfg_t         cfg,
    output logic              flag,
    output logic              pulse
);
    logic dir_ok;
    logic data_hit;
    logic cyc_hit;
    logic hit;

    always_comb begin
        unique case (cfg.func)
            FN_READ:  dir_ok = !bus_write;
            FN_WRITE: dir_ok = bus_write;
            FN_ANY:   dir_ok = 1'b1;
            default:  dir_ok = 1'b0;
        endcase
        data_hit = bus_valid && dir_ok && in_window(bus_addr, cfg.value, cfg.mask);
        cyc_hit  = CYCLE_OK && (cfg.func == FN_CYCLE) && (cyc_cnt == cfg.value);
        hit      = data_hit || cyc_hit;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg   <= '0;
            flag  <= 1'b0;
            pulse <= 1'b0;
        end else begin
            if (wr_value) cfg.value <= wdata;
            if (wr_mask)  cfg.mask  <= wdata[MASK_W-1:0];
            if (wr_func)  cfg.func  <= wdata[FUNC_W-1:0];
            pulse <= hit;
            flag  <= hit || (flag && !flag_clr);
        end
    end
endmodule

// File: rtl/dwatch_unit.sv
module dwatch_unit
    import dwatch_pkg::*;
#(
    parameter int NUM_COMP = NUM_COMP_DEF,
    localparam int IDX_W = (NUM_COMP > 1) ? $clog2(NUM_COMP) : 1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  reg_wr_en,
    input  logic                  reg_rd_en,
    input  logic [REG_ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0]     reg_wdata,
    output logic [DATA_W-1:0]     reg_rdata,
    input  logic                  bus_valid,
    input  logic                  bus_write,
    input  logic [DATA_W-1:0]     bus_addr,
    output logic [NUM_COMP-1:0]   match_pulse
);
    reg_sel_e          dec_sel;
    logic [IDX_W-1:0]  dec_idx;
    logic              ctrl_en;
    logic [DATA_W-1:0] cyc_cnt;
    comp_cfg_t         cfg [NUM_COMP];
    logic [NUM_COMP-1:0] flag;
    logic [DATA_W-1:0] rd_val;

    dwatch_decode #(.NUM_COMP(NUM_COMP)) u_dec (
        .addr (reg_addr),
        .sel  (dec_sel),
        .idx  (dec_idx)
    );

    always_ff @(posedge clk) begin
        if (rst) ctrl_en <= 1'b0;
        else if (reg_wr_en && dec_sel == SEL_CTRL) ctrl_en <= reg_wdata[0];
    end

    dwatch_cyccnt u_cnt (
        .clk      (clk),
        .rst      (rst),
        .run      (ctrl_en),
        .load     (reg_wr_en && dec_sel == SEL_CNT),
        .load_val (reg_wdata),
        .count    (cyc_cnt)
    );

    for (genvar n = 0; n < NUM_COMP; n++) begin : g_comp
        logic here;
        assign here = (dec_idx == IDX_W'(n));
        dwatch_comparator #(.CYCLE_OK(n == 0)) u_cmp (
            .clk       (clk),
            .rst       (rst),
            .wr_value  (reg_wr_en && here && dec_sel == SEL_CVAL),
            .wr_mask   (reg_wr_en && here && dec_sel == SEL_CMASK),
            .wr_func   (reg_wr_en && here && dec_sel == SEL_CFUNC),
            .wdata     (reg_wdata),
            .flag_clr  (reg_rd_en && here && dec_sel == SEL_CFUNC),
            .bus_valid (bus_valid),
            .bus_write (bus_write),
            .bus_addr  (bus_addr),
            .cyc_cnt   (cyc_cnt),
            .cfg       (cfg[n]),
            .flag      (flag[n]),
            .pulse     (match_pulse[n])
        );
    end

    always_comb begin
        rd_val = '0;
        unique case (dec_sel)
            SEL_CTRL: begin
                rd_val[DATA_W-1:ID_LSB] = 4'(NUM_COMP);
                rd_val[0] = ctrl_en;
            end
            SEL_CNT:   rd_val = cyc_cnt;
            SEL_CVAL:  rd_val = cfg[dec_idx].value;
            SEL_CMASK: rd_val[MASK_W-1:0] = cfg[dec_idx].mask;
            SEL_CFUNC: begin
                rd_val[FUNC_W-1:0] = cfg[dec_idx].func;
                rd_val[FLAG_BIT]   = flag[dec_idx];
            end
            default:   rd_val = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)            reg_rdata <= '0;
        else if (reg_rd_en) reg_rdata <= rd_val;
        else                reg_rdata <= '0;
    end
endmodule

// File: rtl/dwatch_checker.sv
module dwatch_checker
    import dwatch_pkg::*;
#(
    parameter int NUM_COMP = NUM_COMP_DEF
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  reg_wr_en,
    input logic                  reg_rd_en,
    input logic [REG_ADDR_W-1:0] reg_addr,
    input logic [DATA_W-1:0]     reg_wdata,
    input logic [DATA_W-1:0]     reg_rdata,
    input logic                  bus_valid,
    input logic [NUM_COMP-1:0]   match_pulse,
    input logic                  ctrl_en,
    input logic [DATA_W-1:0]     cyc_cnt
);
    logic cnt_wr;
    assign cnt_wr = reg_wr_en && (reg_addr == OFF_CNT);

    p_count_step_r3: assert property (@(posedge clk) disable iff (rst)
        (ctrl_en && !cnt_wr) |=> (cyc_cnt == $past(cyc_cnt) + DATA_W'(1)));

    p_count_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (!ctrl_en && !cnt_wr) |=> $stable(cyc_cnt));

    p_count_load_r4: assert property (@(posedge clk) disable iff (rst)
        cnt_wr |=> (cyc_cnt == $past(reg_wdata)));

    p_id_field_r2: assert property (@(posedge clk) disable iff (rst)
        (reg_rd_en && reg_addr == OFF_CTRL) |=> (reg_rdata[DATA_W-1:ID_LSB] == 4'(NUM_COMP)));

    p_rdata_idle_r12: assert property (@(posedge clk) disable iff (rst)
        !reg_rd_en |=> (reg_rdata == '0));

    p_data_needs_bus_r7: assert property (@(posedge clk) disable iff (rst)
        ((match_pulse >> 1) != '0) |-> $past(bus_valid));
endmodule

bind dwatch_unit dwatch_checker #(.NUM_COMP(NUM_COMP)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .reg_wr_en   (reg_wr_en),
    .reg_rd_en   (reg_rd_en),
    .reg_addr    (reg_addr),
    .reg_wdata   (reg_wdata),
    .reg_rdata   (reg_rdata),
    .bus_valid   (bus_valid),
    .match_pulse (match_pulse),
    .ctrl_en     (ctrl_en),
    .cyc_cnt     (cyc_cnt)
);

// File: tb/dwatch_unit_test.sv
module dwatch_unit_test;
    localparam int CLK_PERIOD = 10;
    localparam int NC = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr_en = 1'b0;
    logic        reg_rd_en = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [31:0] bus_addr = '0;
    logic [NC-1:0] match_pulse;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    logic [31:0] m_val  [NC];
    logic [3:0]  m_mask [NC];
    logic [3:0]  m_func [NC];

    dwatch_unit uut (
        .clk(clk), .rst(rst), .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
        .match_pulse(match_pulse)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic reg_write(logic [11:0] a, logic [31:0] d);
        reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
        tick();
        reg_wr_en = 1'b0;
    endtask

    task automatic reg_read(logic [11:0] a, output logic [31:0] d);
        reg_rd_en = 1'b1; reg_addr = a;
        tick();
        reg_rd_en = 1'b0;
        d = reg_rdata;
    endtask

    function automatic logic [11:0] coff(int n, int sub);
        return 12'(32'h20 + 32'h10 * n + sub);
    endfunction

    task automatic prog(int n, logic [31:0] v, logic [3:0] m, logic [3:0] f);
        reg_write(coff(n, 0), v);
        reg_write(coff(n, 4), {28'h0, m});
        reg_write(coff(n, 8), {28'h0, f});
        m_val[n] = v; m_mask[n] = m; m_func[n] = f;
    endtask

    function automatic logic exp_hit(int n, logic v, logic w, logic [31:0] a);
        logic [31:0] keep;
        keep = ~((32'd1 << m_mask[n]) - 32'd1);
        if (!v) return 1'b0;
        if ((a & keep) != (m_val[n] & keep)) return 1'b0;
        if (m_func[n] == 4'd5) return !w;
        if (m_func[n] == 4'd6) return w;
        if (m_func[n] == 4'd7) return 1'b1;
        return 1'b0;
    endfunction

    function automatic logic [NC-1:0] exp_vec(logic v, logic w, logic [31:0] a);
        logic [NC-1:0] r;
        for (int n = 0; n < NC; n++) r[n] = exp_hit(n, v, w, a);
        return r;
    endfunction

    // Drives one access, checks the pulse one cycle later and its end the cycle after.
    task automatic access(string tag, logic w, logic [31:0] a);
        logic [NC-1:0] e;
        e = exp_vec(1'b1, w, a);
        bus_valid = 1'b1; bus_write = w; bus_addr = a;
        tick();
        bus_valid = 1'b0;
        check(tag, 32'(match_pulse), 32'(e));
        tick();
        check("R9 pulse lasts one cycle", 32'(match_pulse), 32'h0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        logic [31:0] a;
        int p0;
        int p1;
        void'($urandom(32'd4242));
        for (int n = 0; n < NC; n++) begin
            m_val[n] = '0; m_mask[n] = '0; m_func[n] = '0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        check("R1 pulses after reset", 32'(match_pulse), 32'h0);
        reg_read(12'h000, d); check("R1 control after reset", d, 32'h4000_0000);
        reg_read(12'h004, d); check("R1 counter after reset", d, 32'h0);
        reg_read(coff(2, 0), d); check("R1 compare value after reset", d, 32'h0);
        reg_read(coff(3, 8), d); check("R1 function after reset", d, 32'h0);

        // R12: idle cycle after a read returns zero
        tick(); check("R12 rdata idle", reg_rdata, 32'h0);

        // R2: control field layout
        reg_write(12'h000, 32'hFFFF_FFFF);
        reg_read(12'h000, d); check("R2 control readback", d, 32'h4000_0001);

        // R3/R4: counting, loading, wrap
        reg_write(12'h004, 32'h0000_1000);
        reg_read(12'h004, d); check("R4 counter load", d, 32'h0000_1000);
        reg_read(12'h004, d); check("R3 counter step", d, 32'h0000_1001);
        reg_read(12'h004, d); check("R3 counter step 2", d, 32'h0000_1002);
        reg_write(12'h004, 32'hFFFF_FFFF);
        reg_read(12'h004, d); check("R4 counter at max", d, 32'hFFFF_FFFF);
        reg_read(12'h004, d); check("R4 counter wraps", d, 32'h0);
        reg_write(12'h000, 32'h0);
        reg_write(12'h004, 32'd77);
        repeat (5) tick();
        reg_read(12'h004, d); check("R3 counter holds when disabled", d, 32'd77);

        // R5: comparator register layout
        reg_write(coff(3, 0), 32'h1234_5678);
        reg_write(coff(3, 4), 32'h0000_00FF);
        reg_write(coff(3, 8), 32'h0000_0065);
        reg_read(coff(3, 0), d); check("R5 value readback", d, 32'h1234_5678);
        reg_read(coff(3, 4), d); check("R5 mask readback", d, 32'h0000_000F);
        reg_read(coff(3, 8), d); check("R5 function readback", d, 32'h0000_0005);
        reg_write(coff(3, 8), 32'h0);

        // R11: holes
        reg_write(12'h00C, 32'hDEAD_BEEF);
        reg_read(12'h00C, d); check("R11 hole write ignored", d, 32'h0);
        reg_read(12'h010, d); check("R11 hole reads zero", d, 32'h0);
        reg_read(12'h060, d); check("R11 past last comparator", d, 32'h0);
        reg_read(12'h004, d); check("R11 counter untouched by hole write", d, 32'd77);

        // R6/R7 directed
        for (int n = 0; n < NC; n++) prog(n, 32'h0, 4'd0, 4'd0);
        prog(1, 32'h0000_1000, 4'd12, 4'd7);
        access("R6 window top byte", 1'b0, 32'h0000_1FFF);
        access("R6 just past window", 1'b1, 32'h0000_2000);
        access("R6 just below window", 1'b0, 32'h0000_0FFF);
        prog(2, 32'h0000_4003, 4'd0, 4'd5);
        access("R7 read on read-only comparator", 1'b0, 32'h0000_4003);
        access("R7 write on read-only comparator", 1'b1, 32'h0000_4003);
        access("R6 exact mask neighbour", 1'b0, 32'h0000_4002);
        prog(2, 32'h0000_4003, 4'd0, 4'd6);
        access("R7 write on write-only comparator", 1'b1, 32'h0000_4003);
        access("R7 read on write-only comparator", 1'b0, 32'h0000_4003);
        prog(0, 32'h0000_8000, 4'd15, 4'd7);
        access("R6 32KB window", 1'b1, 32'h0000_FFFC);

        // R10: sticky flag read and clear
        reg_read(coff(1, 8), d); check("R10 flag set", d, 32'h0100_0007);
        reg_read(coff(1, 8), d); check("R10 flag cleared by read", d, 32'h0000_0007);
        reg_read(coff(3, 8), d); check("R10 flag stays clear without match", d, 32'h0);

        // R8: cycle count match on comparator 0 only
        reg_write(12'h000, 32'h1);
        prog(0, 32'd1000, 4'd0, 4'd0);
        prog(1, 32'd1005, 4'd0, 4'd0);
        reg_read(coff(1, 8), d);
        reg_write(12'h004, 32'd990);
        reg_write(coff(0, 8), 32'h1);
        reg_write(coff(1, 8), 32'h1);
        m_func[0] = 4'd1; m_func[1] = 4'd1;
        p0 = 0; p1 = 0;
        for (int i = 0; i < 30; i++) begin
            tick();
            if (match_pulse[0]) p0++;
            if (match_pulse[1]) p1++;
        end
        check("R8 cycle match fires once", 32'(p0), 32'd1);
        check("R8 code 1 disabled on comparator 1", 32'(p1), 32'd0);
        reg_read(coff(0, 8), d); check("R8 R10 cycle match flag", d, 32'h0100_0001);
        reg_read(coff(1, 8), d); check("R8 no flag on comparator 1", d, 32'h0000_0001);
        reg_write(12'h000, 32'h0);

        // R6/R7/R9 random
        for (int round = 0; round < 8; round++) begin
            for (int n = 0; n < NC; n++) begin
                logic [3:0] f;
                case ($urandom % 7)
                    0: f = 4'd0;
                    1: f = 4'd5;
                    2: f = 4'd6;
                    3: f = 4'd7;
                    4: f = 4'd3;
                    5: f = (n == 0) ? 4'd7 : 4'd1;
                    default: f = 4'd7;
                endcase
                prog(n, $urandom & 32'h0003_FFFF, 4'($urandom % 16), f);
            end
            for (int k = 0; k < 40; k++) begin
                int n;
                n = int'($urandom % NC);
                case ($urandom % 3)
                    0: a = m_val[n] ^ ($urandom & ((32'd1 << ($urandom % 18)) - 32'd1));
                    1: a = m_val[n] ^ (32'd1 << ($urandom % 20));
                    default: a = $urandom & 32'h0003_FFFF;
                endcase
                access("R6 R7 random access", 1'($urandom % 2), a);
            end
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule